// File: doc/BRIEF.md
# I2C Target Interface with Programming-Cycle Lockout

This block is the serial front end of an I2C register or nonvolatile-memory device. SCL and SDA are passed through a synchroniser into the system clock domain. From those synchronised samples the block recognises START, repeated START and STOP conditions. It then decodes the first byte of each transfer as a 7-bit device address followed by a direction bit. After that it either receives data bytes from the controller and hands each one to the user logic, or it fetches bytes from the user logic and shifts them out. The acknowledge for every byte takes place in a ninth SCL clock.

A `busy_i` input stands for an internal programming cycle. While `busy_i` is high, the target does not acknowledge any byte, and that includes its own address. The controller therefore sees no device on the bus until the cycle finishes. On the user side the block has three connections: a one-cycle write strobe carrying the received byte, a one-cycle read request followed by a data return, and an open-drain drive enable for SDA. The target never stretches the clock. It changes SDA only while SCL is low, and only a fixed number of system clocks after the falling edge.

Top module: `i2c_busy_target`

## Requirements
- R1: A STOP (SDA rising while SCL is high) returns the target to idle and releases SDA (`sda_oe` = 0). Bytes clocked after a STOP without a new START get no acknowledge and produce no strobe.
- R2: The first byte after a START is the device address, MSB first, followed by the direction bit (1 = read, 0 = write). When the address equals `DEV_ADDR` and `busy_i` is low, the target holds `sda_oe` = 1 (SDA low) for the whole high period of the ninth SCL pulse.
- R3: When the address does not match, the target gives no acknowledge. It keeps SDA released and raises neither `wr_strobe` nor `rd_req` until the next START or STOP.
- R4: If `busy_i` is high when SCL falls after the eighth bit of an address byte or a write data byte, that byte gets no acknowledge and no `wr_strobe`. The target then ignores the bus until the next START or STOP.
- R5: In write mode every received data byte (MSB first) appears on `wr_data` together with a one-cycle `wr_strobe`, and the target acknowledges it.
- R6: In read mode, `rd_req` pulses for one cycle after the SCL fall that ends the address acknowledge, or after a controller ACK. `rd_data` is captured one clock after the `rd_req` cycle. The byte is sent MSB first, and SDA is released during the controller's acknowledge clock.
- R7: After the controller answers a read byte with a NACK, the target leaves SDA released and issues no further `rd_req` until the next START.
- R8: A repeated START at any bit position abandons the byte in progress without a strobe and begins a new address phase, which may choose a new direction.
- R9: `sda_oe` is asserted only while SCL is low, `DRIVE_DELAY` system clocks after the synchronised falling edge. The only changes made while SCL is high are releases caused by START or STOP.
- R10: While reset is held and straight after it, `sda_oe`, `wr_strobe` and `rd_req` are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | SCL line level |
| sda_i | input | 1 | SDA line level |
| busy_i | input | 1 | High during an internal programming cycle |
| sda_oe | output | 1 | 1 pulls SDA low (open drain) |
| wr_strobe | output | 1 | One-cycle pulse: a received write byte is on wr_data |
| wr_data | output | 8 | Last received write byte |
| rd_req | output | 1 | One-cycle request for the next byte to send |
| rd_data | input | 8 | Byte returned for a read, captured one clock after rd_req |

## Verification
The assertions check the following on every cycle:
- START and STOP release SDA at once.
- SDA only starts to be driven while the synchronised SCL is low.
- The acknowledge is held low through the high phase of SCL.
- A byte that ends while busy never enters an acknowledge phase.
- The ignore state stays silent.
- The strobes are single-cycle and mutually exclusive.

Only the bench's scenarios can show the rest: which bytes arrive in which order, that read data comes out MSB first and in request order, that a NACK stops further requests, and that a repeated START in mid-byte produces no strobe.

// File: rtl/i2c_tgt_pkg.sv
package i2c_tgt_pkg;

  localparam int BYTE_W = 8;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ADDR,
    ST_ADDR_ACK,
    ST_WR_DATA,
    ST_WR_ACK,
    ST_RD_DATA,
    ST_RD_ACK,
    ST_IGNORE
  } tgt_state_e;

  typedef enum logic [1:0] {
    COND_NONE,
    COND_START,
    COND_STOP
  } bus_cond_e;

  // Classify a pair of consecutive synchronised samples of the bus.
  function automatic bus_cond_e classify(logic scl_prev, logic scl_now,
                                         logic sda_prev, logic sda_now);
    if (scl_prev && scl_now && sda_prev && !sda_now) return COND_START;
    if (scl_prev && scl_now && !sda_prev && sda_now) return COND_STOP;
    return COND_NONE;
  endfunction

  // Upper seven bits of the first byte hold the address, bit 0 the direction.
  function automatic logic addr_hit(logic [BYTE_W-1:0] first_byte, logic [6:0] own);
    return first_byte[BYTE_W-1:1] == own;
  endfunction

  function automatic logic [BYTE_W-1:0] shift_in(logic [BYTE_W-1:0] cur, logic b);
    return {cur[BYTE_W-2:0], b};
  endfunction

  function automatic logic [BYTE_W-1:0] shift_out(logic [BYTE_W-1:0] cur);
    return {cur[BYTE_W-2:0], 1'b1};
  endfunction

endpackage

// File: rtl/i2c_tgt_sync.sv
module i2c_tgt_sync
  import i2c_tgt_pkg::*;
#(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_s,
  output logic sda_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_ev,
  output logic stop_ev
);

  logic [STAGES-1:0] scl_pipe;
  logic [STAGES-1:0] sda_pipe;
  logic              scl_q;
  logic              sda_q;
  bus_cond_e         cond;

  for (genvar g = 0; g < STAGES; g++) begin : g_stage
    if (g == 0) begin : g_first
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          scl_pipe[g] <= 1'b1;
          sda_pipe[g] <= 1'b1;
        end else begin
          scl_pipe[g] <= scl_i;
          sda_pipe[g] <= sda_i;
        end
      end
    end else begin : g_next
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          scl_pipe[g] <= 1'b1;
          sda_pipe[g] <= 1'b1;
        end else begin
          scl_pipe[g] <= scl_pipe[g-1];
          sda_pipe[g] <= sda_pipe[g-1];
        end
      end
    end
  end

  assign scl_s = scl_pipe[STAGES-1];
  assign sda_s = sda_pipe[STAGES-1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_q <= 1'b1;
      sda_q <= 1'b1;
    end else begin
      scl_q <= scl_s;
      sda_q <= sda_s;
    end
  end

  assign cond     = classify(scl_q, scl_s, sda_q, sda_s);
  assign start_ev = (cond == COND_START);
  assign stop_ev  = (cond == COND_STOP);
  assign scl_rise = scl_s && !scl_q;
  assign scl_fall = !scl_s && scl_q;

endmodule

// File: rtl/i2c_tgt_drive.sv
module i2c_tgt_drive #(
  parameter int DELAY = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic arm,
  input  logic clear,
  input  logic want_low,
  output logic sda_oe,
  output logic fire
);

  localparam int CW = $clog2(DELAY + 1);

  logic [CW-1:0] cnt;

  assign fire = (cnt == CW'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt    <= '0;
      sda_oe <= 1'b0;
    end else if (clear) begin
      cnt    <= '0;
      sda_oe <= 1'b0;
    end else begin
      if (arm) begin
        cnt <= CW'(DELAY);
      end else if (cnt != '0) begin
        cnt <= cnt - 1'b1;
      end
      if (fire) begin
        sda_oe <= want_low;
      end
    end
  end

endmodule

// File: rtl/i2c_busy_target.sv
module i2c_busy_target
  import i2c_tgt_pkg::*;
#(
  parameter logic [6:0] DEV_ADDR    = 7'h52,
  parameter int         SYNC_STAGES = 2,
  parameter int         DRIVE_DELAY = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              scl_i,
  input  logic              sda_i,
  input  logic              busy_i,
  output logic              sda_oe,
  output logic              wr_strobe,
  output logic [BYTE_W-1:0] wr_data,
  output logic              rd_req,
  input  logic [BYTE_W-1:0] rd_data
);

  localparam int CNT_W = $clog2(BYTE_W + 1);

  // Synchronised bus and events
  logic scl_s, sda_s, scl_rise, scl_fall, start_ev, stop_ev;

  // Protocol state
  tgt_state_e        state;
  logic [CNT_W-1:0]  bit_cnt;
  logic [BYTE_W-1:0] rx_sh;
  logic [BYTE_W-1:0] tx_sh;
  logic              rw_q;
  logic              ctl_ack_q;
  logic              rd_load_q;

  // Named internal events for the checker
  logic byte_end_ev;
  logic ack_phase;
  logic addr_phase;
  logic ign_phase;
  logic sda_low_req;
  logic drive_fire;

  i2c_tgt_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk      (clk),
    .rst_n    (rst_n),
    .scl_i    (scl_i),
    .sda_i    (sda_i),
    .scl_s    (scl_s),
    .sda_s    (sda_s),
    .scl_rise (scl_rise),
    .scl_fall (scl_fall),
    .start_ev (start_ev),
    .stop_ev  (stop_ev)
  );

  assign byte_end_ev = scl_fall && (bit_cnt == CNT_W'(BYTE_W));
  assign ack_phase   = (state == ST_ADDR_ACK) || (state == ST_WR_ACK);
  assign addr_phase  = (state == ST_ADDR);
  assign ign_phase   = (state == ST_IGNORE);

  always_comb begin
    case (state)
      ST_ADDR_ACK, ST_WR_ACK: sda_low_req = 1'b1;
      ST_RD_DATA:             sda_low_req = !tx_sh[BYTE_W-1];
      default:                sda_low_req = 1'b0;
    endcase
  end

  i2c_tgt_drive #(.DELAY(DRIVE_DELAY)) u_drive (
    .clk      (clk),
    .rst_n    (rst_n),
    .arm      (scl_fall),
    .clear    (start_ev || stop_ev),
    .want_low (sda_low_req),
    .sda_oe   (sda_oe),
    .fire     (drive_fire)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= ST_IDLE;
      bit_cnt   <= '0;
      rx_sh     <= '0;
      tx_sh     <= '1;
      rw_q      <= 1'b0;
      ctl_ack_q <= 1'b0;
      rd_load_q <= 1'b0;
      wr_strobe <= 1'b0;
      wr_data   <= '0;
      rd_req    <= 1'b0;
    end else begin
      wr_strobe <= 1'b0;
      rd_req    <= 1'b0;
      rd_load_q <= rd_req;
      if (start_ev) begin
        state   <= ST_ADDR;
        bit_cnt <= '0;
      end else if (stop_ev) begin
        state   <= ST_IDLE;
        bit_cnt <= '0;
      end else begin
        case (state)
          ST_ADDR, ST_WR_DATA: begin
            if (scl_rise) begin
              rx_sh   <= shift_in(rx_sh, sda_s);
              bit_cnt <= bit_cnt + 1'b1;
            end else if (byte_end_ev) begin
              bit_cnt <= '0;
              if (state == ST_ADDR) begin
                if (addr_hit(rx_sh, DEV_ADDR) && !busy_i) begin
                  state <= ST_ADDR_ACK;
                  rw_q  <= rx_sh[0];
                end else begin
                  state <= ST_IGNORE;
                end
              end else if (!busy_i) begin
                state     <= ST_WR_ACK;
                wr_strobe <= 1'b1;
                wr_data   <= rx_sh;
              end else begin
                state <= ST_IGNORE;
              end
            end
          end
          ST_ADDR_ACK: begin
            if (scl_fall) begin
              if (rw_q) begin
                state  <= ST_RD_DATA;
                rd_req <= 1'b1;
              end else begin
                state <= ST_WR_DATA;
              end
            end
          end
          ST_WR_ACK: begin
            if (scl_fall) state <= ST_WR_DATA;
          end
          ST_RD_DATA: begin
            if (scl_rise) begin
              bit_cnt <= bit_cnt + 1'b1;
            end else if (scl_fall) begin
              if (bit_cnt == CNT_W'(BYTE_W)) begin
                state   <= ST_RD_ACK;
                bit_cnt <= '0;
              end else begin
                tx_sh <= shift_out(tx_sh);
              end
            end
          end
          ST_RD_ACK: begin
            if (scl_rise) begin
              ctl_ack_q <= !sda_s;
            end else if (scl_fall) begin
              if (ctl_ack_q) begin
                state  <= ST_RD_DATA;
                rd_req <= 1'b1;
              end else begin
                state <= ST_IGNORE;
              end
            end
          end
          default: ;
        endcase
      end
      if (rd_load_q) tx_sh <= rd_data;
    end
  end

endmodule

// File: rtl/i2c_busy_target_chk.sv
module i2c_busy_target_chk (
  input logic clk,
  input logic rst_n,
  input logic scl_s,
  input logic start_ev,
  input logic stop_ev,
  input logic scl_fall,
  input logic byte_end_ev,
  input logic busy_i,
  input logic sda_oe,
  input logic wr_strobe,
  input logic rd_req,
  input logic ack_phase,
  input logic addr_phase,
  input logic ign_phase
);

  // R10: outputs quiet out of reset
  a_r10_reset_quiet: assert property (@(posedge clk)
    !rst_n |=> (!sda_oe && !wr_strobe && !rd_req));

  // R1: STOP releases SDA at once
  a_r1_stop_release: assert property (@(posedge clk) disable iff (!rst_n)
    stop_ev |=> !sda_oe);

  // R8: START (also repeated) enters the address phase with SDA released
  a_r8_start_to_addr: assert property (@(posedge clk) disable iff (!rst_n)
    start_ev |=> (addr_phase && !sda_oe));

  // R9: drive changes only after SCL seen low, unless START/STOP released it
  a_r9_drive_scl_low: assert property (@(posedge clk) disable iff (!rst_n)
    (!$stable(sda_oe) && !$past(start_ev) && !$past(stop_ev)) |-> !$past(scl_s));

  // R2: the acknowledge is held low for the high period of the ninth clock
  a_r2_ack_held: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_phase && scl_s) |-> sda_oe);

  // R4: a byte ending during a programming cycle never reaches an ack phase
  a_r4_busy_no_ack: assert property (@(posedge clk) disable iff (!rst_n)
    (byte_end_ev && busy_i) |=> !ack_phase);

  // R3: ignoring state is silent on the bus and on the user side
  a_r3_ignore_silent: assert property (@(posedge clk) disable iff (!rst_n)
    ign_phase |-> (!sda_oe && !wr_strobe && !rd_req));

  // R5: write strobe follows an SCL fall
  a_r5_strobe_on_fall: assert property (@(posedge clk) disable iff (!rst_n)
    wr_strobe |-> $past(scl_fall));

  // R6: read request is a single-cycle pulse after an SCL fall
  a_r6_req_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    rd_req |-> ($past(scl_fall) && !$past(rd_req)));

  // R6: user strobes never overlap
  a_r6_strobes_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({wr_strobe, rd_req}));

endmodule

bind i2c_busy_target i2c_busy_target_chk u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .scl_s       (scl_s),
  .start_ev    (start_ev),
  .stop_ev     (stop_ev),
  .scl_fall    (scl_fall),
  .byte_end_ev (byte_end_ev),
  .busy_i      (busy_i),
  .sda_oe      (sda_oe),
  .wr_strobe   (wr_strobe),
  .rd_req      (rd_req),
  .ack_phase   (ack_phase),
  .addr_phase  (addr_phase),
  .ign_phase   (ign_phase)
);

// File: tb/test_i2c_busy_target.sv
`timescale 1ns/100ps
module test_i2c_busy_target;

  localparam logic [6:0] ADDR = 7'h52;
  localparam int HP = 20;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       scl_ln = 1'b1;
  logic       sda_ctl = 1'b1;
  logic       busy = 1'b0;
  logic       sda_oe;
  logic       wr_strobe;
  logic [7:0] wr_data;
  logic       rd_req;
  logic [7:0] rd_data = 8'h00;
  logic       sda_line;

  int vectors = 0;
  int miscompares = 0;
  int wr_cnt = 0;
  int rd_cnt = 0;
  logic [7:0] exp_wr[$];
  logic oe_prev = 1'b0;

  always #2.5 clk = ~clk;

  assign sda_line = sda_ctl & ~sda_oe;

  i2c_busy_target #(.DEV_ADDR(ADDR)) i_i2c_busy_target (
    .clk       (clk),
    .rst_n     (rst_n),
    .scl_i     (scl_ln),
    .sda_i     (sda_line),
    .busy_i    (busy),
    .sda_oe    (sda_oe),
    .wr_strobe (wr_strobe),
    .wr_data   (wr_data),
    .rd_req    (rd_req),
    .rd_data   (rd_data)
  );

  function automatic logic [7:0] rd_pat(int n);
    return 8'((n * 37 + 90) & 255);
  endfunction

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    vectors++;
    if (!ok) begin
      miscompares++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // User side: registered data return, one byte per request
  always @(posedge clk) begin
    if (rd_req) begin
      rd_data <= rd_pat(rd_cnt);
      rd_cnt  <= rd_cnt + 1;
    end
  end

  // Write-side reference: each strobe must match the next expected byte
  always @(negedge clk) begin
    if (rst_n && wr_strobe) begin
      wr_cnt++;
      if (exp_wr.size() == 0) begin
        check(1'b0, "R5", "unexpected wr_strobe", wr_data, 0);
      end else begin
        logic [7:0] e;
        e = exp_wr.pop_front();
        check(wr_data == e, "R5", "wr_data", wr_data, e);
      end
    end
  end

  // R9 monitor: the target may only start pulling SDA while SCL is low
  always @(negedge clk) begin
    if (rst_n && sda_oe && !oe_prev)
      check(!scl_ln, "R9", "sda_oe asserted with SCL high", scl_ln, 0);
    oe_prev <= sda_oe;
  end

  task automatic wait_clk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bus_start();
    sda_ctl = 1'b1; wait_clk(HP);
    scl_ln  = 1'b1; wait_clk(HP);
    sda_ctl = 1'b0; wait_clk(HP);
    scl_ln  = 1'b0; wait_clk(2);
  endtask

  task automatic bus_stop();
    sda_ctl = 1'b0; wait_clk(HP);
    scl_ln  = 1'b1; wait_clk(HP);
    sda_ctl = 1'b1; wait_clk(HP);
  endtask

  task automatic clock_bit(input logic b);
    sda_ctl = b;    wait_clk(HP);
    scl_ln  = 1'b1; wait_clk(HP);
    scl_ln  = 1'b0; wait_clk(2);
  endtask

  task automatic send_byte(input logic [7:0] b, output bit acked);
    logic a1, a2;
    for (int i = 7; i >= 0; i--) clock_bit(b[i]);
    sda_ctl = 1'b1; wait_clk(HP);
    scl_ln  = 1'b1; wait_clk(2);
    a1 = sda_line;  wait_clk(HP - 3);
    a2 = sda_line;  wait_clk(1);
    scl_ln  = 1'b0; wait_clk(2);
    acked = !a1 && !a2;
  endtask

  task automatic recv_byte(input bit ack, output logic [7:0] b, output bit released);
    sda_ctl = 1'b1;
    for (int i = 7; i >= 0; i--) begin
      wait_clk(HP);
      scl_ln = 1'b1; wait_clk(HP / 2);
      b[i] = sda_line; wait_clk(HP / 2);
      scl_ln = 1'b0; wait_clk(2);
    end
    sda_ctl = !ack; wait_clk(HP);
    scl_ln  = 1'b1; wait_clk(HP / 2);
    released = !sda_oe; wait_clk(HP / 2);
    scl_ln  = 1'b0; wait_clk(2);
    sda_ctl = 1'b1;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    check(1'b0, "R1", "watchdog expired", 0, 1);
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    bit ack;
    bit rel;
    logic [7:0] rb;
    int wr_base;
    int rd_base;

    wait_clk(5);
    check(!sda_oe && !wr_strobe && !rd_req, "R10", "outputs during reset",
          {sda_oe, wr_strobe, rd_req}, 0);
    rst_n = 1'b1;
    wait_clk(5);
    check(!sda_oe && !wr_strobe && !rd_req, "R10", "outputs after reset",
          {sda_oe, wr_strobe, rd_req}, 0);

    // Write transfer, several patterns
    bus_start();
    send_byte({ADDR, 1'b0}, ack);
    check(ack, "R2", "address ack (write)", ack, 1);
    foreach (exp_wr[i]) ;
    begin
      logic [7:0] pats[4] = '{8'h3C, 8'hC3, 8'h00, 8'hFF};
      for (int k = 0; k < 4; k++) begin
        exp_wr.push_back(pats[k]);
        send_byte(pats[k], ack);
        check(ack, "R5", "write data ack", ack, 1);
      end
    end
    bus_stop();
    wait_clk(10);
    check(!sda_oe, "R1", "SDA released after STOP", sda_oe, 0);
    check(wr_cnt == 4 && exp_wr.size() == 0, "R5", "write strobe count", wr_cnt, 4);

    // Byte after STOP without START is ignored
    scl_ln = 1'b0; wait_clk(2);
    wr_base = wr_cnt;
    send_byte({ADDR, 1'b0}, ack);
    check(!ack, "R1", "no ack without START", ack, 0);
    check(wr_cnt == wr_base, "R1", "no strobe without START", wr_cnt, wr_base);

    // Address mismatch
    bus_start();
    send_byte({ADDR ^ 7'h01, 1'b0}, ack);
    check(!ack, "R3", "mismatched address not acked", ack, 0);
    send_byte(8'h55, ack);
    check(!ack, "R3", "data after mismatch not acked", ack, 0);
    check(wr_cnt == wr_base, "R3", "no strobe after mismatch", wr_cnt, wr_base);
    bus_stop();

    // Busy during address phase
    busy = 1'b1;
    bus_start();
    send_byte({ADDR, 1'b0}, ack);
    check(!ack, "R4", "own address not acked while busy", ack, 0);
    send_byte(8'h77, ack);
    check(!ack, "R4", "data not acked while busy", ack, 0);
    bus_stop();
    busy = 1'b0;
    check(wr_cnt == wr_base, "R4", "no strobe while busy", wr_cnt, wr_base);

    // Busy rising in the middle of a write
    bus_start();
    send_byte({ADDR, 1'b0}, ack);
    check(ack, "R2", "address ack before busy", ack, 1);
    exp_wr.push_back(8'h11);
    send_byte(8'h11, ack);
    check(ack, "R5", "data ack before busy", ack, 1);
    busy = 1'b1;
    send_byte(8'h22, ack);
    check(!ack, "R4", "byte ending in busy not acked", ack, 0);
    busy = 1'b0;
    send_byte(8'h33, ack);
    check(!ack, "R4", "target stays off bus after busy byte", ack, 0);
    bus_stop();
    check(wr_cnt == wr_base + 1, "R4", "only pre-busy byte strobed", wr_cnt, wr_base + 1);

    // Read transfer
    rd_base = rd_cnt;
    bus_start();
    send_byte({ADDR, 1'b1}, ack);
    check(ack, "R2", "address ack (read)", ack, 1);
    for (int k = 0; k < 3; k++) begin
      recv_byte(k < 2, rb, rel);
      check(rb == rd_pat(rd_base + k), "R6", "read byte MSB first", rb, rd_pat(rd_base + k));
      check(rel, "R6", "SDA released in controller ack clock", rel, 1);
    end
    wait_clk(10);
    check(!sda_oe, "R7", "SDA released after NACK", sda_oe, 0);
    check(rd_cnt == rd_base + 3, "R7", "request count after NACK", rd_cnt, rd_base + 3);
    recv_byte(1'b0, rb, rel);
    check(rb == 8'hFF, "R7", "bus idle high after NACK", rb, 8'hFF);
    check(rd_cnt == rd_base + 3, "R7", "no request after NACK", rd_cnt, rd_base + 3);
    bus_stop();

    // Repeated START mid-byte, then switch to read
    wr_base = wr_cnt;
    bus_start();
    send_byte({ADDR, 1'b0}, ack);
    check(ack, "R2", "address ack before restart", ack, 1);
    clock_bit(1'b1);
    clock_bit(1'b1);
    clock_bit(1'b0);
    bus_start();
    send_byte({ADDR, 1'b1}, ack);
    check(ack, "R8", "new address phase after repeated START", ack, 1);
    recv_byte(1'b0, rb, rel);
    check(rb == rd_pat(rd_base + 3), "R8", "read after repeated START", rb, rd_pat(rd_base + 3));
    bus_stop();
    wait_clk(10);
    check(wr_cnt == wr_base, "R8", "aborted byte not strobed", wr_cnt, wr_base);
    check(!sda_oe, "R1", "released at end", sda_oe, 0);

    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

endmodule